// File: doc/BRIEF.md
# Oscillator Enable and Failure Monitor

This block sits beside the timekeeping counters of a real-time clock. It holds the oscillator stop control and the calibration setting, and it keeps a shadow copy of the time registers that the host last wrote. A digital watchdog watches the raw oscillator signal for transitions. The oscillator counts as dead when no transition has come through for a window of system clocks.

The block checks the oscillator only when a power-on event happens, which is a rising edge on the power-good input. If the stop control leaves the oscillator enabled and the watchdog sees no activity at that moment, the block sets a sticky failure flag. It also pulses a reload strobe for one cycle, so the timekeeping counters take the shadowed base time. A failure never alters the stop control, the calibration value or the shadow copy. Software clears the flag by writing a zero to it, or by initialising the clock through any time-register write.

Top module: `osc_fail_monitor`

## Requirements
- R1: After reset the failure flag is 0, the reload strobe is 0, the oscillator run output is 1 (stop bit 0), the calibration value is 0 and the base time is all zeros.
- R2: A write to address 1 sets the stop bit from data bit 7 and the calibration value from data bits 5:0. From the next cycle, the run output equals the inverse of the stop bit.
- R3: The oscillator counts as alive when a transition on the oscillator input, after two synchroniser stages, was seen within the last WIN system clocks. Otherwise it counts as dead.
- R4: When pwr_good is sampled high after being sampled low, the stop bit is 0 and the oscillator is dead, the failure flag is 1 from the next cycle and the reload strobe is high for exactly that one cycle.
- R5: A power-on event does not set the flag or pulse the reload strobe when the oscillator is alive or when the stop bit is 1.
- R6: The failure flag is sticky. A write to address 0 with data bit 0 equal to 0 clears it, and a write with data bit 0 equal to 1 leaves it unchanged.
- R7: A write to any time register (addresses 2 to 2+TIME_REGS-1) clears the failure flag.
- R8: A write to address 2+k stores the data into base_time[8k+7:8k]. A failure event leaves base_time unchanged.
- R9: A failure event leaves the stop bit and the calibration value unchanged.
- R10: When a power-on failure and a flag-clearing write fall in the same cycle, the flag ends up set.
- R11: Writes to addresses above the last time register change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_good | input | 1 | Main supply above switch-over level |
| osc_in | input | 1 | Raw oscillator signal (asynchronous) |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | ADDR_W | Host write address |
| wr_data | input | DATA_W | Host write data |
| osc_fail | output | 1 | Sticky oscillator failure flag |
| reload_stb | output | 1 | One-cycle strobe: load base time into the counters |
| osc_run | output | 1 | Oscillator run control (inverse of stop bit) |
| cal_val | output | CAL_W | Calibration setting |
| base_time | output | TIME_REGS*TIME_W | Last-written time register values |

## Verification
The hardest case to reach from the ports is a power-on event that lands exactly while the watchdog judges the oscillator dead and the stop bit is clear. It takes a supply drop and rise, a silent oscillator for longer than the window, and the right control setting, all at once. The stimulus drives the oscillator input from a bench process that can be switched between toggling every cycle and holding still. It waits a chosen number of cycles before dropping and raising pwr_good, and it mixes this with random stop settings and random writes that sometimes land in the same cycle as the power-on event.

// File: rtl/osc_mon_pkg.sv
package osc_mon_pkg;
    // register addresses
    localparam int unsigned ADDR_FLAG  = 0;
    localparam int unsigned ADDR_CTRL  = 1;
    localparam int unsigned ADDR_TIME0 = 2;
    // field positions
    localparam int unsigned FLAG_BIT = 0;
    localparam int unsigned STOP_BIT = 7;
endpackage

// File: rtl/osc_activity_mon.sv
module osc_activity_mon #(
    parameter int unsigned WIN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_in,
    output logic alive
);
    localparam int unsigned CNT_W = $clog2(WIN + 1);

    typedef struct packed {
        logic [2:0]       sync;
        logic [CNT_W-1:0] cnt;
    } act_t;

    act_t act_d, act_q;
    logic seen_edge;

    always_comb begin
        act_d      = act_q;
        act_d.sync = {act_q.sync[1:0], osc_in};
        seen_edge  = act_q.sync[1] ^ act_q.sync[2];
        if (seen_edge)
            act_d.cnt = '0;
        else if (act_q.cnt < CNT_W'(WIN))
            act_d.cnt = act_q.cnt + 1'b1;
        alive = act_q.cnt < CNT_W'(WIN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q.sync <= '0;
            act_q.cnt  <= CNT_W'(WIN);
        end else begin
            act_q <= act_d;
        end
    end
endmodule

// File: rtl/osc_shadow_bank.sv
module osc_shadow_bank #(
    parameter int unsigned TIME_REGS = 4,
    parameter int unsigned TIME_W    = 8,
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned BASE_ADDR = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [TIME_W-1:0]           wr_data,
    output logic [TIME_REGS*TIME_W-1:0] base_time
);
    logic [TIME_W-1:0] bank_d [TIME_REGS];
    logic [TIME_W-1:0] bank_q [TIME_REGS];

    for (genvar k = 0; k < TIME_REGS; k++) begin : g_slot
        always_comb begin
            bank_d[k] = bank_q[k];
            if (wr_en && wr_addr == ADDR_W'(BASE_ADDR + k))
                bank_d[k] = wr_data;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bank_q[k] <= '0;
            else        bank_q[k] <= bank_d[k];
        end

        assign base_time[k*TIME_W +: TIME_W] = bank_q[k];
    end
endmodule

// File: rtl/osc_fail_monitor.sv
module osc_fail_monitor
    import osc_mon_pkg::*;
#(
    parameter int unsigned TIME_REGS = 4,
    parameter int unsigned TIME_W    = 8,
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned CAL_W     = 6,
    parameter int unsigned WIN       = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        pwr_good,
    input  logic                        osc_in,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [DATA_W-1:0]           wr_data,
    output logic                        osc_fail,
    output logic                        reload_stb,
    output logic                        osc_run,
    output logic [CAL_W-1:0]            cal_val,
    output logic [TIME_REGS*TIME_W-1:0] base_time
);
    localparam int unsigned TIME_END = ADDR_TIME0 + TIME_REGS;

    typedef struct packed {
        logic             pg;
        logic             fail;
        logic             stop;
        logic [CAL_W-1:0] cal;
        logic             reload;
    } mon_t;

    mon_t mon_d, mon_q;
    logic alive;
    logic flag_wr, ctrl_wr, time_wr, pwr_event, fail_hit;

    osc_activity_mon #(.WIN(WIN)) i_act (
        .clk    (clk),
        .rst_n  (rst_n),
        .osc_in (osc_in),
        .alive  (alive)
    );

    osc_shadow_bank #(
        .TIME_REGS (TIME_REGS),
        .TIME_W    (TIME_W),
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (ADDR_TIME0)
    ) i_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data[TIME_W-1:0]),
        .base_time (base_time)
    );

    always_comb begin
        flag_wr   = wr_en && (wr_addr == ADDR_W'(ADDR_FLAG));
        ctrl_wr   = wr_en && (wr_addr == ADDR_W'(ADDR_CTRL));
        time_wr   = wr_en && (wr_addr >= ADDR_W'(ADDR_TIME0))
                          && (wr_addr <  ADDR_W'(TIME_END));
        pwr_event = pwr_good && !mon_q.pg;
        fail_hit  = pwr_event && !mon_q.stop && !alive;

        mon_d        = mon_q;
        mon_d.pg     = pwr_good;
        mon_d.reload = fail_hit;
        if (ctrl_wr) begin
            mon_d.stop = wr_data[STOP_BIT];
            mon_d.cal  = wr_data[CAL_W-1:0];
        end
        if ((flag_wr && !wr_data[FLAG_BIT]) || time_wr)
            mon_d.fail = 1'b0;
        if (fail_hit)
            mon_d.fail = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mon_q <= '0;
        else        mon_q <= mon_d;
    end

    assign osc_fail   = mon_q.fail;
    assign reload_stb = mon_q.reload;
    assign osc_run    = !mon_q.stop;
    assign cal_val    = mon_q.cal;
endmodule

// File: rtl/osc_fail_monitor_chk.sv
module osc_fail_monitor_chk
    import osc_mon_pkg::*;
#(
    parameter int unsigned TIME_REGS = 4,
    parameter int unsigned TIME_W    = 8,
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned CAL_W     = 6
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        pwr_good,
    input logic                        wr_en,
    input logic [ADDR_W-1:0]           wr_addr,
    input logic [DATA_W-1:0]           wr_data,
    input logic                        osc_fail,
    input logic                        reload_stb,
    input logic                        osc_run,
    input logic [CAL_W-1:0]            cal_val,
    input logic [TIME_REGS*TIME_W-1:0] base_time
);
    localparam int unsigned TIME_END = ADDR_TIME0 + TIME_REGS;

    p_reload_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reload_stb |=> !reload_stb);

    p_reload_sets_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reload_stb |-> osc_fail);

    p_flag_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(osc_fail) |-> reload_stb && $past(pwr_good));

    p_ctrl_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(ADDR_CTRL))
        |=> (osc_run == !$past(wr_data[STOP_BIT]))
            && (cal_val == $past(wr_data[CAL_W-1:0])));

    p_fail_keeps_ctrl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_stb && !$past(wr_en)) |-> $stable(osc_run) && $stable(cal_val));

    p_fail_keeps_base_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_stb && !$past(wr_en)) |-> $stable(base_time));

    p_high_addr_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr >= ADDR_W'(TIME_END))
        |=> $stable(base_time) && $stable(osc_run) && $stable(cal_val));
endmodule

bind osc_fail_monitor osc_fail_monitor_chk #(
    .TIME_REGS (TIME_REGS),
    .TIME_W    (TIME_W),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .CAL_W     (CAL_W)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_good   (pwr_good),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .osc_fail   (osc_fail),
    .reload_stb (reload_stb),
    .osc_run    (osc_run),
    .cal_val    (cal_val),
    .base_time  (base_time)
);

// File: tb/test_osc_fail_monitor.sv
`timescale 1ns/1ps
module test_osc_fail_monitor;
    localparam int CLK_PERIOD = 10;
    localparam int TIME_REGS  = 4;
    localparam int TIME_W     = 8;
    localparam int ADDR_W     = 4;
    localparam int DATA_W     = 8;
    localparam int CAL_W      = 6;
    localparam int WIN        = 16;

    logic clk = 0;
    logic rst_n = 0;
    logic pwr_good = 0;
    logic osc_in = 0;
    logic wr_en = 0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic osc_fail, reload_stb, osc_run;
    logic [CAL_W-1:0] cal_val;
    logic [TIME_REGS*TIME_W-1:0] base_time;

    osc_fail_monitor #(
        .TIME_REGS(TIME_REGS), .TIME_W(TIME_W), .ADDR_W(ADDR_W),
        .DATA_W(DATA_W), .CAL_W(CAL_W), .WIN(WIN)
    ) i_osc_fail_monitor (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .osc_in(osc_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .osc_fail(osc_fail), .reload_stb(reload_stb), .osc_run(osc_run),
        .cal_val(cal_val), .base_time(base_time)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // oscillator stand-in
    logic osc_toggle = 0;
    always @(negedge clk) if (osc_toggle) osc_in <= ~osc_in;

    // reference model
    int  n_checks = 0;
    int  n_fails  = 0;
    bit  m_fail = 0;
    bit  m_stop = 0;
    logic [CAL_W-1:0] m_cal = '0;
    logic [TIME_W-1:0] m_base [TIME_REGS];
    bit  m_alive = 0;

    function automatic logic [TIME_REGS*TIME_W-1:0] pack_base();
        logic [TIME_REGS*TIME_W-1:0] v;
        for (int k = 0; k < TIME_REGS; k++) v[k*TIME_W +: TIME_W] = m_base[k];
        return v;
    endfunction

    function automatic void apply_write(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
        if (a == 0) begin
            if (!d[0]) m_fail = 0;
        end else if (a == 1) begin
            m_stop = d[7];
            m_cal  = d[CAL_W-1:0];
        end else if (a < 2 + TIME_REGS) begin
            m_base[a-2] = d[TIME_W-1:0];
            m_fail = 0;
        end
    endfunction

    task automatic check_bit(string req, string what, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic check_all(string req, bit exp_reload);
        check_bit(req, "osc_fail", osc_fail, m_fail);
        check_bit(req, "reload_stb", reload_stb, exp_reload);
        check_bit(req, "osc_run", osc_run, !m_stop);
        n_checks++;
        if (cal_val !== m_cal || base_time !== pack_base()) begin
            n_fails++;
            $display("FAIL %s cal/base: actual %h/%h expected %h/%h",
                     req, cal_val, base_time, m_cal, pack_base());
        end
    endtask

    task automatic do_write(string req, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
        apply_write(a, d);
        check_all(req, 0);
    endtask

    // R3: choose oscillator activity and let the watchdog settle
    task automatic set_osc(bit run, int settle);
        @(negedge clk);
        osc_toggle = run;
        repeat (settle) @(negedge clk);
        m_alive = run;
    endtask

    // power drop and rise; optional write in the rise cycle
    task automatic pwr_cycle(string req, bit with_wr, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
        bit hit;
        @(negedge clk);
        pwr_good = 0;
        @(negedge clk);
        pwr_good = 1;
        if (with_wr) begin wr_en = 1; wr_addr = a; wr_data = d; end
        hit = !m_stop && !m_alive;
        @(negedge clk);
        wr_en = 0;
        if (with_wr) apply_write(a, d);
        if (hit) m_fail = 1;
        check_all(req, hit);
        @(negedge clk);
        check_all(req, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0107));
        for (int k = 0; k < TIME_REGS; k++) m_base[k] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_all("R1", 0);

        // R2 control write, then restore
        do_write("R2", 1, 8'hA5);
        do_write("R2", 1, 8'h13);
        // R8 shadow writes
        for (int k = 0; k < TIME_REGS; k++) do_write("R8", ADDR_W'(2 + k), DATA_W'(8'h30 + k));

        // R5 alive oscillator: no failure
        set_osc(1, 4);
        pwr_cycle("R5", 0, 0, 0);
        // R3 short silence still counts as alive
        set_osc(0, 4);
        m_alive = 1;
        pwr_cycle("R3", 0, 0, 0);
        // R5 dead but stopped
        do_write("R2", 1, 8'h80);
        set_osc(0, WIN + 6);
        pwr_cycle("R5", 0, 0, 0);
        // R4 / R9 / R8 dead and enabled
        do_write("R2", 1, 8'h2A);
        pwr_cycle("R4", 0, 0, 0);
        // R6 writing 1 leaves flag
        do_write("R6", 0, 8'h01);
        check_bit("R6", "flag kept", osc_fail, 1'b1);
        // R11 high address ignored
        do_write("R11", 4'hF, 8'hFF);
        do_write("R11", 4'h6, 8'h00);
        // R6 clear by writing 0
        do_write("R6", 0, 8'h00);
        check_bit("R6", "flag cleared", osc_fail, 1'b0);
        // R7 time write clears
        pwr_cycle("R4", 0, 0, 0);
        do_write("R7", 3, 8'h77);
        check_bit("R7", "flag cleared", osc_fail, 1'b0);
        // R10 collision with clear
        pwr_cycle("R10", 1, 0, 8'h00);
        check_bit("R10", "set wins", osc_fail, 1'b1);
        pwr_cycle("R10", 1, 2, 8'h5C);
        check_bit("R10", "set wins time", osc_fail, 1'b1);

        // random mix
        for (int i = 0; i < 300; i++) begin
            int op;
            op = int'($urandom_range(0, 4));
            case (op)
                0: do_write("R2", 1, DATA_W'($urandom));
                1: do_write("R6", 0, DATA_W'($urandom_range(0, 1)));
                2: do_write("R8", ADDR_W'($urandom_range(2, 1 + TIME_REGS)), DATA_W'($urandom));
                3: do_write("R11", ADDR_W'($urandom_range(2 + TIME_REGS, 15)), DATA_W'($urandom));
                default: begin
                    if ($urandom_range(0, 1) == 1) set_osc(1, 4);
                    else                           set_osc(0, WIN + 6);
                    if ($urandom_range(0, 2) == 0)
                        pwr_cycle("R4", 1, ADDR_W'($urandom_range(0, 5)), DATA_W'($urandom));
                    else
                        pwr_cycle("R4", 0, 0, 0);
                end
            endcase
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule